// File: doc/BRIEF.md
# E-paper panel bring-up and full-refresh sequencer

This block runs the control side of a monochrome e-paper panel that is built from two cascaded driver controllers. It owns the panel's active-low reset line and watches the panel's active-high busy line. It emits a fixed script of command and data bytes to a downstream byte-wide SPI shifter, one byte at a time, over a valid/ready handshake. With each byte it passes a data/command flag and a chip-select framing flag.

A one-cycle `start` together with a two-bit `op` code launches one of three scripts. The first pulses the panel's reset line. The second initialises the controllers, including two temperature/waveform load activations. The third sets the full-panel RAM window on both controllers and fires a full refresh. Delays are counted in milliseconds. The millisecond tick comes from a prescaler whose length is a parameter, so a simulation can shorten it. No busy wait can hang: each one gives up after its own timeout and raises a warning flag.

Top module: `epaper_seq`

## Requirements
- R1: After reset, `pnl_rst_n` is 1, `sh_valid`, `run`, `done` and `timeout_warn` are 0, and `sh_cs_n` is 1.
- R2: The reset script (op 0) drives `pnl_rst_n` high, low and high again. Each level is held for RST_MS milliseconds, where one millisecond is CLK_PER_MS cycles, so the low phase lasts RST_MS*CLK_PER_MS+1 cycles. A busy wait of BSY_RST_MS follows.
- R3: In a busy wait, `pnl_busy` is seen through a SYNC_STAGES-flop synchroniser. It is polled on the first cycle of the wait and at every millisecond boundary, and the wait ends at the first poll that sees it low. If it is still high when the timeout expires, the script moves on and `timeout_warn` is set. `timeout_warn` stays set until the next accepted start clears it.
- R4: While `sh_valid` is high, `sh_data` and `sh_dc` hold steady until `sh_ready` is high. Exactly one byte is transferred per cycle in which both are high.
- R5: Command bytes carry `sh_dc`=0 and data bytes carry `sh_dc`=1. `sh_cs_n` is low exactly while a byte is offered. It rises for one cycle after every command byte and after the last byte of a data burst, and stays low between the bytes of one burst.
- R6: The init script (op 1) sends 12 bytes in this order:
  - 0x12, then a SETTLE_MS delay and a busy wait;
  - 0x18 with 0x80;
  - 0x22 with 0xB1, then 0x20, a delay and a busy wait;
  - 0x1A with 0x64,0x00;
  - 0x22 with 0x91, then 0x20, a delay and a busy wait.

  Each busy wait in this script has a BSY_INIT_MS timeout.
- R7: The update script (op 2) first sets the RAM window on the secondary controller (offset t=0x80) and then on the primary (t=0x00). Each window is:
  - 0x11|t with 0x03;
  - 0x44|t with 0x00,XE;
  - 0x45|t with 0x00,0x00,YE low byte,YE high byte;
  - 0x4E|t with 0x00;
  - 0x4F|t with 0x00,0x00.

  Here XE=(PANEL_W/2-1)/8 and YE=PANEL_H-1. The script then sends 0x21 with 0x40,0x10; 0x1A with 0x64,0x00; 0x22 with 0xD7; and 0x20. It ends with a busy wait of BSY_UPD_MS. In total it sends 39 bytes.
- R8: `start` is accepted only when `run` is low and `op` is not 3. A start with op 3, or any start while a script runs, has no effect.
- R9: `run` is high from the cycle after an accepted start until the script ends. `done` is a one-cycle pulse in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request |
| op | input | 2 | Script select: 0 reset, 1 init, 2 update, 3 none |
| pnl_busy | input | 1 | Panel busy, active high, asynchronous |
| sh_ready | input | 1 | Shifter accepts the offered byte |
| pnl_rst_n | output | 1 | Panel reset, active low |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_data | output | 8 | Offered byte |
| sh_dc | output | 1 | 1 = data byte, 0 = command byte |
| sh_cs_n | output | 1 | Chip-select framing, active low |
| run | output | 1 | A script is in progress |
| done | output | 1 | Script finished (one-cycle pulse) |
| timeout_warn | output | 1 | A busy wait expired during the last script |

## Verification
The bench holds `sh_ready` low at irregular points and checks every offered byte against its own script tables. A design that advanced without a handshake would drop or repeat bytes. A design that framed the burst wrongly would toggle chip-select inside a data burst.

The busy input is released at a point that does not line up with the millisecond boundaries, which catches a design that ends its wait on the wrong poll. It is also held high through the long refresh wait, which catches a design that hangs or fails to raise the warning. The bench also measures the length of the low reset phase exactly. It issues a start in the middle of a script, which must be ignored, and a start with op 3, which must also be ignored.

// File: rtl/eps_pkg.sv
package eps_pkg;

   localparam int ARG_W = 12;
   localparam int IDX_W = 6;

   typedef enum logic [2:0] {
      K_END, K_RST, K_DLY, K_BSY, K_CMD, K_DAT
   } kind_e;

   typedef enum logic [1:0] {
      OP_RESET, OP_INIT, OP_UPDATE, OP_NONE
   } op_e;

   typedef enum logic [1:0] {
      S_IDLE, S_RUN, S_GAP
   } state_e;

   // One script step: arg is a byte for CMD/DAT, a level for RST,
   // a millisecond count for DLY/BSY.
   typedef struct packed {
      kind_e            kind;
      logic [ARG_W-1:0] arg;
      logic             last;
   } step_t;

endpackage

// File: rtl/eps_tick.sv
module eps_tick #(
   parameter int CLK_PER_MS = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   if (CLK_PER_MS == 1) begin : g_direct
      assign tick = en;
   end else begin : g_count
      localparam int CW = $clog2(CLK_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (clr)    cnt <= '0;
         else if (en)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign tick = en && (cnt == LAST);
   end
endmodule

// File: rtl/eps_script.sv
module eps_script
   import eps_pkg::*;
#(
   parameter int PANEL_W     = 792,
   parameter int PANEL_H     = 272,
   parameter int RST_MS      = 20,
   parameter int SETTLE_MS   = 10,
   parameter int BSY_RST_MS  = 100,
   parameter int BSY_INIT_MS = 100,
   parameter int BSY_UPD_MS  = 2500
) (
   input  op_e              op,
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);
   localparam logic [7:0]  XE = 8'((PANEL_W / 2 - 1) / 8);
   localparam logic [15:0] YE = 16'(PANEL_H - 1);
   localparam int WIN_LEN = 15;

   function automatic step_t cmd(logic [7:0] b);
      return '{kind: K_CMD, arg: {{(ARG_W-8){1'b0}}, b}, last: 1'b1};
   endfunction

   function automatic step_t dat(logic [7:0] b, logic l);
      return '{kind: K_DAT, arg: {{(ARG_W-8){1'b0}}, b}, last: l};
   endfunction

   function automatic step_t tim(kind_e k, int ms);
      return '{kind: k, arg: ARG_W'(ms), last: 1'b0};
   endfunction

   function automatic step_t fin();
      return '{kind: K_END, arg: '0, last: 1'b0};
   endfunction

   // Full-panel RAM window for one controller; t is its command offset.
   function automatic step_t win(logic [IDX_W-1:0] k, logic [7:0] t);
      case (k)
         0:  return cmd(8'h11 | t);
         1:  return dat(8'h03, 1'b1);
         2:  return cmd(8'h44 | t);
         3:  return dat(8'h00, 1'b0);
         4:  return dat(XE, 1'b1);
         5:  return cmd(8'h45 | t);
         6:  return dat(8'h00, 1'b0);
         7:  return dat(8'h00, 1'b0);
         8:  return dat(YE[7:0], 1'b0);
         9:  return dat(YE[15:8], 1'b1);
         10: return cmd(8'h4E | t);
         11: return dat(8'h00, 1'b1);
         12: return cmd(8'h4F | t);
         13: return dat(8'h00, 1'b0);
         default: return dat(8'h00, 1'b1);
      endcase
   endfunction

   logic [IDX_W-1:0] j;
   assign j = idx - IDX_W'(2 * WIN_LEN);

   always_comb begin
      step = fin();
      case (op)
         OP_RESET: case (idx)
            0: step = '{kind: K_RST, arg: ARG_W'(1), last: 1'b0};
            1: step = tim(K_DLY, RST_MS);
            2: step = '{kind: K_RST, arg: '0, last: 1'b0};
            3: step = tim(K_DLY, RST_MS);
            4: step = '{kind: K_RST, arg: ARG_W'(1), last: 1'b0};
            5: step = tim(K_DLY, RST_MS);
            6: step = tim(K_BSY, BSY_RST_MS);
            default: step = fin();
         endcase
         OP_INIT: case (idx)
            0:  step = cmd(8'h12);
            1:  step = tim(K_DLY, SETTLE_MS);
            2:  step = tim(K_BSY, BSY_INIT_MS);
            3:  step = cmd(8'h18);
            4:  step = dat(8'h80, 1'b1);
            5:  step = cmd(8'h22);
            6:  step = dat(8'hB1, 1'b1);
            7:  step = cmd(8'h20);
            8:  step = tim(K_DLY, SETTLE_MS);
            9:  step = tim(K_BSY, BSY_INIT_MS);
            10: step = cmd(8'h1A);
            11: step = dat(8'h64, 1'b0);
            12: step = dat(8'h00, 1'b1);
            13: step = cmd(8'h22);
            14: step = dat(8'h91, 1'b1);
            15: step = cmd(8'h20);
            16: step = tim(K_DLY, SETTLE_MS);
            17: step = tim(K_BSY, BSY_INIT_MS);
            default: step = fin();
         endcase
         OP_UPDATE: begin
            if (idx < IDX_W'(WIN_LEN))
               step = win(idx, 8'h80);
            else if (idx < IDX_W'(2 * WIN_LEN))
               step = win(idx - IDX_W'(WIN_LEN), 8'h00);
            else case (j)
               0: step = cmd(8'h21);
               1: step = dat(8'h40, 1'b0);
               2: step = dat(8'h10, 1'b1);
               3: step = cmd(8'h1A);
               4: step = dat(8'h64, 1'b0);
               5: step = dat(8'h00, 1'b1);
               6: step = cmd(8'h22);
               7: step = dat(8'hD7, 1'b1);
               8: step = cmd(8'h20);
               9: step = tim(K_BSY, BSY_UPD_MS);
               default: step = fin();
            endcase
         end
         default: step = fin();
      endcase
   end
endmodule

// File: rtl/epaper_seq.sv
module epaper_seq
   import eps_pkg::*;
#(
   parameter int CLK_PER_MS  = 200000,
   parameter int SYNC_STAGES = 2,
   parameter int PANEL_W     = 792,
   parameter int PANEL_H     = 272,
   parameter int RST_MS      = 20,
   parameter int SETTLE_MS   = 10,
   parameter int BSY_RST_MS  = 100,
   parameter int BSY_INIT_MS = 100,
   parameter int BSY_UPD_MS  = 2500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] op,
   input  logic       pnl_busy,
   input  logic       sh_ready,
   output logic       pnl_rst_n,
   output logic       sh_valid,
   output logic [7:0] sh_data,
   output logic       sh_dc,
   output logic       sh_cs_n,
   output logic       run,
   output logic       done,
   output logic       timeout_warn
);
   localparam int MS_MAX = (1 << ARG_W) - 1;

   if (CLK_PER_MS < 1) begin : g_bad_clk
      $error("CLK_PER_MS must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end
   if (RST_MS < 1 || SETTLE_MS < 1 || BSY_RST_MS < 1 || BSY_INIT_MS < 1 ||
       BSY_UPD_MS < 1 || RST_MS > MS_MAX || SETTLE_MS > MS_MAX ||
       BSY_RST_MS > MS_MAX || BSY_INIT_MS > MS_MAX || BSY_UPD_MS > MS_MAX) begin : g_bad_ms
      $error("millisecond counts must lie in 1..2**ARG_W-1");
   end
   if (PANEL_W < 16 || (PANEL_W / 2 - 1) / 8 > 255 || PANEL_H < 2 || PANEL_H > 65536) begin : g_bad_panel
      $error("panel size outside the addressable window");
   end

   // ---------------- busy synchroniser ----------------
   logic busy_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign busy_s = pnl_busy;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else begin
            chain[0] <= pnl_busy;
            for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         end
      end
      assign busy_s = chain[SYNC_STAGES-1];
   end

   // ---------------- state ----------------
   state_e           state;
   op_e              op_q;
   logic [IDX_W-1:0] idx;
   logic [ARG_W-1:0] ms_cnt;
   logic             fresh, rst_q, warn_q, done_q;
   step_t            step;
   logic             timed, tick, adv, gap, fin, to_warn, poll, last_ms;

   eps_script #(
      .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .RST_MS(RST_MS),
      .SETTLE_MS(SETTLE_MS), .BSY_RST_MS(BSY_RST_MS),
      .BSY_INIT_MS(BSY_INIT_MS), .BSY_UPD_MS(BSY_UPD_MS)
   ) u_script (
      .op(op_q), .idx(idx), .step(step)
   );

   assign timed = (state == S_RUN) && (step.kind == K_DLY || step.kind == K_BSY);

   eps_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(timed), .clr(adv), .tick(tick)
   );

   assign poll    = fresh || tick;
   assign last_ms = (ms_cnt == step.arg - ARG_W'(1));

   always_comb begin
      adv = 1'b0; gap = 1'b0; fin = 1'b0; to_warn = 1'b0;
      if (state == S_RUN) begin
         case (step.kind)
            K_RST: adv = 1'b1;
            K_DLY: adv = tick && last_ms;
            K_BSY: begin
               if (poll && !busy_s) adv = 1'b1;
               else if (tick && last_ms) begin
                  adv = 1'b1; to_warn = 1'b1;
               end
            end
            K_CMD: begin adv = sh_ready; gap = 1'b1; end
            K_DAT: begin adv = sh_ready; gap = step.last; end
            default: fin = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= OP_RESET;
         idx    <= '0;
         ms_cnt <= '0;
         fresh  <= 1'b0;
         rst_q  <= 1'b1;
         warn_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: if (start && op_e'(op) != OP_NONE) begin
               state  <= S_RUN;
               op_q   <= op_e'(op);
               idx    <= '0;
               ms_cnt <= '0;
               fresh  <= 1'b1;
               warn_q <= 1'b0;
            end
            S_RUN: if (fin) begin
               state  <= S_IDLE;
               done_q <= 1'b1;
            end else begin
               if (step.kind == K_RST) rst_q <= step.arg[0];
               if (to_warn) warn_q <= 1'b1;
               if (adv) begin
                  idx    <= idx + 1'b1;
                  ms_cnt <= '0;
                  fresh  <= 1'b1;
                  if (gap) state <= S_GAP;
               end else begin
                  fresh <= 1'b0;
                  if (tick) ms_cnt <= ms_cnt + 1'b1;
               end
            end
            default: state <= S_RUN;
         endcase
      end
   end

   assign sh_valid     = (state == S_RUN) && (step.kind == K_CMD || step.kind == K_DAT);
   assign sh_data      = step.arg[7:0];
   assign sh_dc        = (step.kind == K_DAT);
   assign sh_cs_n      = !sh_valid;
   assign run          = (state != S_IDLE);
   assign done         = done_q;
   assign pnl_rst_n    = rst_q;
   assign timeout_warn = warn_q;
endmodule

// File: rtl/eps_chk.sv
module eps_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       run,
   input logic       done,
   input logic       timeout_warn,
   input logic       pnl_rst_n,
   input logic       sh_valid,
   input logic       sh_ready,
   input logic [7:0] sh_data,
   input logic       sh_dc,
   input logic       sh_cs_n
);
   a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      sh_valid && !sh_ready |=> sh_valid && $stable(sh_data) && $stable(sh_dc));

   a_r5_cs_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      sh_valid && sh_ready && !sh_dc |=> sh_cs_n);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run);

   a_r8_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(start));

   a_r2_reset_in_script: assert property (@(posedge clk) disable iff (!rst_n)
      !pnl_rst_n |-> run);

   a_r3_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_warn && !(start && !run) |=> timeout_warn);
endmodule

bind epaper_seq eps_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .run(run), .done(done),
   .timeout_warn(timeout_warn), .pnl_rst_n(pnl_rst_n), .sh_valid(sh_valid),
   .sh_ready(sh_ready), .sh_data(sh_data), .sh_dc(sh_dc), .sh_cs_n(sh_cs_n)
);

// File: tb/sim_epaper_seq.sv
`timescale 1ns/1ps
module sim_epaper_seq;
   localparam int P    = 8;
   localparam int SYNC = 2;
   localparam int KE = 0, KR = 1, KD = 2, KB = 3, KC = 4, KT = 5;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pnl_busy = 1'b0, sh_ready = 1'b1;
   logic [1:0] op = 2'd0;
   logic pnl_rst_n, sh_valid, sh_dc, sh_cs_n, run, done, timeout_warn;
   logic [7:0] sh_data;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   epaper_seq #(.CLK_PER_MS(P), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pnl_busy(pnl_busy),
      .sh_ready(sh_ready), .pnl_rst_n(pnl_rst_n), .sh_valid(sh_valid),
      .sh_data(sh_data), .sh_dc(sh_dc), .sh_cs_n(sh_cs_n), .run(run),
      .done(done), .timeout_warn(timeout_warn)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // ---------------- reference script tables ----------------
   int mk[$], ma[$], ml[$];
   int cur_op = 0;

   function automatic void put(int k, int a, int l);
      mk.push_back(k); ma.push_back(a); ml.push_back(l);
   endfunction

   function automatic void window(int t);
      put(KC, 'h11 | t, 1); put(KT, 'h03, 1);
      put(KC, 'h44 | t, 1); put(KT, 0, 0); put(KT, (792 / 2 - 1) / 8, 1);
      put(KC, 'h45 | t, 1); put(KT, 0, 0); put(KT, 0, 0);
      put(KT, 271 % 256, 0); put(KT, 271 / 256, 1);
      put(KC, 'h4E | t, 1); put(KT, 0, 1);
      put(KC, 'h4F | t, 1); put(KT, 0, 0); put(KT, 0, 1);
   endfunction

   function automatic void load(int o);
      mk.delete(); ma.delete(); ml.delete();
      if (o == 0) begin
         put(KR, 1, 0); put(KD, 20, 0); put(KR, 0, 0); put(KD, 20, 0);
         put(KR, 1, 0); put(KD, 20, 0); put(KB, 100, 0);
      end else if (o == 1) begin
         put(KC, 'h12, 1); put(KD, 10, 0); put(KB, 100, 0);
         put(KC, 'h18, 1); put(KT, 'h80, 1);
         put(KC, 'h22, 1); put(KT, 'hB1, 1); put(KC, 'h20, 1);
         put(KD, 10, 0); put(KB, 100, 0);
         put(KC, 'h1A, 1); put(KT, 'h64, 0); put(KT, 'h00, 1);
         put(KC, 'h22, 1); put(KT, 'h91, 1); put(KC, 'h20, 1);
         put(KD, 10, 0); put(KB, 100, 0);
      end else begin
         window('h80); window('h00);
         put(KC, 'h21, 1); put(KT, 'h40, 0); put(KT, 'h10, 1);
         put(KC, 'h1A, 1); put(KT, 'h64, 0); put(KT, 'h00, 1);
         put(KC, 'h22, 1); put(KT, 'hD7, 1); put(KC, 'h20, 1);
         put(KB, 2500, 0);
      end
      put(KE, 0, 0);
   endfunction

   // ---------------- cycle model ----------------
   int m_state = 0, m_i = 0, m_el = 0;
   bit m_rst = 1, m_warn = 0, m_done = 0;
   bit hist [SYNC];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_i = 0; m_el = 0; m_rst = 1; m_warn = 0; m_done = 0;
         for (int k = 0; k < SYNC; k++) hist[k] = 0;
      end else begin
         bit bs;
         int k, a, l;
         bs = hist[SYNC-1];
         for (int q = SYNC - 1; q > 0; q--) hist[q] = hist[q-1];
         hist[0] = pnl_busy;
         m_done = 0;
         if (m_state == 0) begin
            if (start && op != 2'd3) begin
               cur_op = op; load(op);
               m_state = 1; m_i = 0; m_el = 0; m_warn = 0;
            end
         end else if (m_state == 2) begin
            m_state = 1;
         end else begin
            k = mk[m_i]; a = ma[m_i]; l = ml[m_i];
            case (k)
               KE: begin m_state = 0; m_done = 1; end
               KR: begin m_rst = a[0]; m_i++; m_el = 0; end
               KD: if (m_el == a * P - 1) begin m_i++; m_el = 0; end
                   else m_el++;
               KB: begin
                  if ((m_el == 0 || (m_el + 1) % P == 0) && !bs) begin
                     m_i++; m_el = 0;
                  end else if (m_el + 1 == a * P) begin
                     m_warn = 1; m_i++; m_el = 0;
                  end else m_el++;
               end
               default: if (sh_ready) begin
                  m_i++; m_el = 0;
                  if (k == KC || l != 0) m_state = 2;
               end
            endcase
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         bit ev;
         string rq;
         ev = (m_state == 1) && (mk[m_i] == KC || mk[m_i] == KT);
         rq = (cur_op == 1) ? "R6" : (cur_op == 2) ? "R7" : "R2";
         chk(sh_valid == ev, rq, sh_valid, ev);
         if (ev && sh_valid) begin
            chk(sh_data == 8'(ma[m_i]), rq, sh_data, ma[m_i]);
            chk(sh_dc == (mk[m_i] == KT), "R5", sh_dc, mk[m_i] == KT);
         end
         chk(sh_cs_n == !ev, "R5", sh_cs_n, !ev);
         chk(pnl_rst_n == m_rst, "R2", pnl_rst_n, m_rst);
         chk(timeout_warn == m_warn, "R3", timeout_warn, m_warn);
         chk(run == (m_state != 0), "R9", run, m_state != 0);
         chk(done == m_done, "R9", done, m_done);
      end
   end

   // ---------------- stimulus helpers ----------------
   int rdy_mode = 0, busy_mode = 0, cyc = 0, bytes = 0, low_cnt = 0;
   logic [7:0] lfsr = 8'hA5;

   always @(negedge clk) begin
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sh_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
      pnl_busy = (busy_mode == 0) ? 1'b0 : (busy_mode == 2) ? 1'b1 : ((cyc % 300) < 203);
   end

   always @(posedge clk) begin
      if (sh_valid && sh_ready) bytes++;
      if (!pnl_rst_n) low_cnt++;
   end

   task automatic launch(input logic [1:0] o);
      @(negedge clk); start = 1'b1; op = o;
      @(negedge clk); start = 1'b0; op = 2'd0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 60000) begin @(negedge clk); n++; end
      if (n >= 60000) chk(0, "R9 watchdog", n, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pnl_rst_n == 1'b1, "R1", pnl_rst_n, 1);
      chk(sh_valid == 1'b0 && sh_cs_n == 1'b1, "R1", {sh_valid, sh_cs_n}, 1);
      chk(run == 1'b0 && done == 1'b0, "R1", {run, done}, 0);
      chk(timeout_warn == 1'b0, "R1", timeout_warn, 0);

      // R8: op 3 is ignored
      launch(2'd3);
      repeat (5) @(negedge clk);
      chk(run == 1'b0, "R8", run, 0);

      // R2: reset script, busy already low
      low_cnt = 0;
      launch(2'd0);
      wait_done();
      chk(low_cnt == 20 * P + 1, "R2", low_cnt, 20 * P + 1);
      chk(timeout_warn == 1'b0, "R3", timeout_warn, 0);

      // R6: init with handshake stalls and busy released mid-wait
      rdy_mode = 1; busy_mode = 1; bytes = 0;
      launch(2'd1);
      wait_done();
      chk(bytes == 12, "R6", bytes, 12);
      chk(timeout_warn == 1'b0, "R3", timeout_warn, 0);

      // R7: update with busy stuck high; R8: start mid-script ignored
      busy_mode = 2; bytes = 0;
      launch(2'd2);
      repeat (50) @(negedge clk);
      launch(2'd0);
      chk(run == 1'b1, "R8", run, 1);
      wait_done();
      chk(bytes == 39, "R7", bytes, 39);
      chk(timeout_warn == 1'b1, "R3", timeout_warn, 1);

      // R3: warning cleared by the next accepted start
      busy_mode = 0; rdy_mode = 0;
      launch(2'd0);
      chk(timeout_warn == 1'b0, "R3", timeout_warn, 0);
      wait_done();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule